// File: doc/BRIEF.md
# Serial Management Bus Master

This block runs single register reads and writes to external transceiver chips over a two-wire serial management bus: a clock line that the block generates and a shared bidirectional data line. A host places a device address, a register address and, for writes, a data word on the inputs. It then pulses a read or a write strobe. The block serialises the frame, releases the data line during the reply on reads, and captures the returned word.

The bus clock is derived from the system clock by a divider setting. Small settings are clamped to the fastest rate, and odd settings are rounded down to an even period. A mode input drops the leading run of ones so frames are shorter. A busy flag covers the whole transaction. The last word read stays on its output until another read finishes.

Top module: `mdio_master`

## Requirements
- R1: A divider setting of 0, 1, 2 or 3 gives a bus clock period of 2 system clocks.
- R2: A divider setting of 4 or more gives a bus clock period equal to the setting with bit 0 cleared, in system clocks.
- R3: With the preamble enabled, a frame is 64 bits on the data line, in this order: 32 ones, start pattern 01, opcode (10 read, 01 write), 5-bit device address MSB first, 5-bit register address MSB first, then 2 turnaround bits and 16 data bits. On a write the turnaround bits are 10 and the data bits are the write word, MSB first.
- R4: With `no_preamble_i` high when the request is taken, the 32 ones are left out and the frame is 32 bits, starting with 01.
- R5: On a read, the output enable is low for the last 18 bit times (turnaround and data). The 16 data bits are sampled on rising bus clock edges, MSB first, and appear on `rdata_o` when busy falls.
- R6: `busy_o` rises the cycle after an accepted request and stays high for exactly (frame bits × bus clock period) cycles. While idle, `mdc_o` is low and `mdio_oe_o` is low.
- R7: While the data line is driven, its value changes only on a falling edge of the bus clock, so it is stable at every rising edge.
- R8: `rdata_o` is 0 after reset. It keeps its value through write transactions and through a read in progress, and changes only when a read completes.
- R9: Strobes that arrive while busy is high are ignored: the running frame, its length, and the idle state after it are unchanged.
- R10: If both strobes are high in the same idle cycle, a read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | 8 | Bus clock divider setting, taken with the request |
| no_preamble_i | input | 1 | Omit the 32 leading ones |
| dev_addr_i | input | 5 | Device address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rd_req_i | input | 1 | Read strobe |
| wr_req_i | input | 1 | Write strobe |
| busy_o | output | 1 | Transaction in progress |
| rdata_o | output | 16 | Last word read |
| mdc_o | output | 1 | Bus clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with its default widths: an 8-bit divider, 5-bit addresses, 16-bit data and a 32-bit preamble. These match the bus, so every real frame format and divider setting can be exercised. Settings 0 to 3 show the clamp, odd settings 7 and 9 show the rounding, and a setting of 255 brings the slowest period (254 clocks) within reach of one 32-bit frame. The bench acts as the far device: it records the line at every rising bus clock edge and drives the reply word during read data bits.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8,
  parameter int PA_W  = 5,
  parameter int RA_W  = 5,
  parameter int D_W   = 16,
  parameter int PRE_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             no_preamble_i,
  input  logic [PA_W-1:0]  dev_addr_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [D_W-1:0]   wdata_i,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  output logic             busy_o,
  output logic [D_W-1:0]   rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  localparam int FR_W  = 6 + PA_W + RA_W + D_W;
  localparam int SH_W  = PRE_N + FR_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam int H_W   = DIV_W - 1;
  localparam int TAIL  = D_W + 2;

  logic [H_W-1:0]   half, hcnt;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] left;
  logic [D_W-1:0]   cap;
  logic             is_rd;

  wire tick   = busy_o && (hcnt == half - H_W'(1));
  wire rise   = tick && !mdc_o;
  wire fall   = tick && mdc_o;
  wire go     = !busy_o && (rd_req_i || wr_req_i);
  wire go_rd  = rd_req_i;
  wire [H_W-1:0] new_half = (div_i < DIV_W'(4)) ? H_W'(1) : div_i[DIV_W-1:1];
  wire [FR_W-1:0] frame = {2'b01, go_rd ? 2'b10 : 2'b01, dev_addr_i, reg_addr_i,
                           go_rd ? 2'b00 : 2'b10, go_rd ? {D_W{1'b0}} : wdata_i};

  assign mdio_o    = sh[SH_W-1];
  assign mdio_oe_o = busy_o && !(is_rd && left <= CNT_W'(TAIL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      mdc_o   <= 1'b0;
      half    <= H_W'(1);
      hcnt    <= '0;
      sh      <= '0;
      left    <= '0;
      is_rd   <= 1'b0;
      cap     <= '0;
      rdata_o <= '0;
    end else if (go) begin
      busy_o <= 1'b1;
      mdc_o  <= 1'b0;
      hcnt   <= '0;
      half   <= new_half;
      is_rd  <= go_rd;
      sh     <= no_preamble_i ? {frame, {PRE_N{1'b0}}} : {{PRE_N{1'b1}}, frame};
      left   <= no_preamble_i ? CNT_W'(FR_W) : CNT_W'(SH_W);
    end else if (busy_o) begin
      if (tick) begin
        hcnt  <= '0;
        mdc_o <= ~mdc_o;
      end else begin
        hcnt <= hcnt + H_W'(1);
      end
      if (rise && is_rd && left <= CNT_W'(D_W))
        cap <= {cap[D_W-2:0], mdio_i};
      if (fall) begin
        if (left == CNT_W'(1)) begin
          busy_o <= 1'b0;
          if (is_rd) rdata_o <= cap;
        end
        sh   <= sh << 1;
        left <= left - CNT_W'(1);
      end
    end
  end

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  a_r6_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $fell(mdc_o));

  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(mdio_o)) |-> $fell(mdc_o));

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> $fell(busy_o));

  a_r1_half_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (half != '0));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic no_preamble_i = 1'b0;
  logic [4:0] dev_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic rd_req_i = 1'b0, wr_req_i = 1'b0;
  logic busy_o, mdc_o, mdio_o, mdio_oe_o, mdio_i;
  logic [15:0] rdata_o;

  mdio_master u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int nr = 0, viol = 0, pre_n = 32;
  logic [63:0] cap, cap_oe;
  logic [15:0] pat = '0;
  logic prev_mdio = 1'b0;

  always @(negedge clk) prev_mdio = mdio_o;
  always @(posedge mdc_o) begin
    if (mdio_oe_o && mdio_o !== prev_mdio) viol++;
    cap    = {cap[62:0], mdio_oe_o ? mdio_o : 1'b0};
    cap_oe = {cap_oe[62:0], mdio_oe_o};
    nr++;
  end
  always @* begin
    if (nr >= pre_n + 16 && nr < pre_n + 32) mdio_i = pat[15 - (nr - pre_n - 16)];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {div, nopre, rd, dev, reg, data}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {8'd0,  1'b0, 1'b0, 5'h01, 5'h1F, 16'hA5C3},
    {8'd1,  1'b0, 1'b1, 5'h01, 5'h03, 16'hDEAD},
    {8'd2,  1'b1, 1'b0, 5'h10, 5'h00, 16'h7DFF},
    {8'd3,  1'b1, 1'b1, 5'h1F, 5'h10, 16'h0001},
    {8'd4,  1'b0, 1'b1, 5'h08, 5'h04, 16'h8000},
    {8'd7,  1'b1, 1'b0, 5'h02, 5'h08, 16'hFFFE},
    {8'd10, 1'b0, 1'b0, 5'h04, 5'h02, 16'h1234},
    {8'd9,  1'b1, 1'b1, 5'h15, 5'h0A, 16'hC35A}
  };

  int busy_cnt;

  task automatic start(input logic [7:0] d, input bit np, input bit rd, input bit wr,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] dat);
    @(negedge clk);
    nr = 0; cap = '0; cap_oe = '0; viol = 0;
    pre_n = np ? 0 : 32; pat = dat;
    div_i = d; no_preamble_i = np; dev_addr_i = pa; reg_addr_i = ra; wdata_i = dat;
    rd_req_i = rd; wr_req_i = wr;
    @(negedge clk);
    rd_req_i = 1'b0; wr_req_i = 1'b0;
    busy_cnt = 0;
  endtask

  task automatic finish_wait;
    while (busy_o) begin busy_cnt++; @(negedge clk); end
  endtask

  task automatic expect_frame(input string tag, input logic [7:0] d, input bit np, input bit rd,
                              input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] dat);
    int per, bits;
    logic [63:0] ef, eo;
    per  = (d < 4) ? 2 : int'(d & 8'hFE);
    bits = np ? 32 : 64;
    ef = rd ? {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 18'h0}
            : {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, dat};
    eo = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    if (np) begin ef = {32'h0, ef[31:0]}; eo = {32'h0, eo[31:0]}; end
    chk(busy_cnt == bits * per, {tag, " R1 R2 R6 busy length"}, busy_cnt, bits * per);
    chk(nr == bits, {tag, " R4 rising edges"}, nr, bits);
    chk(cap == ef, {tag, " R3 R4 frame"}, cap, ef);
    chk(cap_oe == eo, {tag, " R5 output enable"}, cap_oe, eo);
    chk(viol == 0, {tag, " R7 stable at rise"}, viol, 0);
    if (rd) chk(rdata_o == dat, {tag, " R5 read data"}, rdata_o, dat);
  endtask

  logic [15:0] held;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && mdc_o == 0 && mdio_oe_o == 0, "R6 reset idle", {busy_o, mdc_o, mdio_oe_o}, 0);
    chk(rdata_o == 16'h0, "R8 reset rdata", rdata_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      held = rdata_o;
      start(v[35:28], v[27], v[26], !v[26], v[25:21], v[20:16], v[15:0]);
      finish_wait;
      expect_frame($sformatf("vec%0d", i), v[35:28], v[27], v[26], v[25:21], v[20:16], v[15:0]);
      if (!v[26]) chk(rdata_o == held, "R8 write keeps rdata", rdata_o, held);
    end

    // slowest divider
    start(8'd255, 1'b1, 1'b0, 1'b1, 5'h11, 5'h05, 16'h5A5A);
    finish_wait;
    expect_frame("div255", 8'd255, 1'b1, 1'b0, 5'h11, 5'h05, 16'h5A5A);

    // R9: strobes during busy are ignored
    start(8'd4, 1'b0, 1'b0, 1'b1, 5'h03, 5'h06, 16'h0F0F);
    repeat (20) begin busy_cnt++; @(negedge clk); end
    dev_addr_i = 5'h1C; reg_addr_i = 5'h1B; wdata_i = 16'hFFFF; no_preamble_i = 1'b1;
    rd_req_i = 1'b1; wr_req_i = 1'b1;
    busy_cnt++; @(negedge clk);
    rd_req_i = 1'b0; wr_req_i = 1'b0;
    finish_wait;
    expect_frame("R9 busy", 8'd4, 1'b0, 1'b0, 5'h03, 5'h06, 16'h0F0F);
    repeat (4) @(negedge clk);
    chk(busy_o == 0, "R9 no late start", busy_o, 0);

    // R8: rdata held while a read runs
    held = rdata_o;
    start(8'd2, 1'b1, 1'b1, 1'b0, 5'h07, 5'h09, 16'h6B2E);
    repeat (50) begin busy_cnt++; @(negedge clk); end
    chk(rdata_o == held, "R8 hold during read", rdata_o, held);
    finish_wait;
    expect_frame("R8 read", 8'd2, 1'b1, 1'b1, 5'h07, 5'h09, 16'h6B2E);

    // R10: both strobes together -> read
    start(8'd0, 1'b1, 1'b1, 1'b1, 5'h0A, 5'h15, 16'h9C01);
    finish_wait;
    expect_frame("R10 both", 8'd0, 1'b1, 1'b1, 5'h0A, 5'h15, 16'h9C01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20;
    rst_n = 1'b1;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule